// File: doc/BRIEF.md
# Supply and Thermal Fault Supervisor

This block sits between three analog fault comparators (junction over-temperature, supply over-voltage, supply under-voltage) and the sequencer that drives a DC motor full bridge. Each raw comparator flag is first synchronized. It is then filtered, so a condition counts only after it has held steadily for a programmable number of cycles. The filtered state goes to a small arbiter. The arbiter turns it into registered gating controls for the sequencer: a disable for each high-side switch, a disable for each low-side switch, a forced-brake request for the low sides, a timer freeze, a flag telling the sequencer to ignore its command inputs, a timer re-arm pulse and a reset request.

Each fault class gets its own bridge response. Over-temperature opens all four switches. Under-voltage removes the high sides and forces a brake. Over-voltage removes only the high sides and leaves the low sides as commanded, so a braking bridge stays braked and a driving bridge floats one half. It also freezes the run timer. Recovery never latches. When the last over-temperature or under-voltage condition has cleared through the filter, the block spends one cycle re-arming the timer, and also requests a reset if over-temperature was involved. Only after that cycle does it hand control back. The shutdown trigger input passes to a buffered output through the synchronizer alone, so no fault can affect it.

Top module: `fault_supervisor`

## Requirements
- R1: A raw fault flag changes the filtered state only after the synchronized flag has differed from that state for DEB_CYCLES consecutive cycles. A pulse held for DEB_CYCLES-1 cycles has no effect. An accepted change appears at the outputs SYNC_STAGES+DEB_CYCLES+1 cycles after the raw flag changes.
- R2: Removal of a fault passes through the same filter. The gating stays in place until the raw flag has been low for DEB_CYCLES consecutive cycles, and it releases by itself with no latching.
- R3: While over-temperature is filtered active: hs_off=2'b11, ls_off=2'b11, ls_force=0, tmr_freeze=0, cmd_ignore=1.
- R4: When over-temperature has cleared and no under-voltage remains, the outputs hold for exactly one cycle with tmr_rearm=1, reset_req=1, cmd_ignore=1, hs_off=2'b11, ls_off=2'b00, ls_force=1. The cycle after that, normal outputs resume.
- R5: While over-voltage alone is filtered active: hs_off=2'b11, ls_off=2'b00, ls_force=0, tmr_freeze=1, cmd_ignore=1. Its release returns all gating outputs to 0 with no re-arm cycle.
- R6: While under-voltage is filtered active: hs_off=2'b11, ls_off=2'b00, ls_force=1, tmr_freeze=0, cmd_ignore=1. Its release produces one re-arm cycle as in R4, but with reset_req=0.
- R7: When faults overlap, the response of over-temperature wins over under-voltage, and under-voltage wins over over-voltage. The re-arm cycle waits until both over-temperature and under-voltage have cleared. It carries reset_req=1 if over-temperature was seen since the previous re-arm cycle, and tmr_freeze equals the filtered over-voltage state.
- R8: trig_out equals trig_in delayed by SYNC_STAGES cycles, whatever the fault state.
- R9: After reset every gating output is 0.
- R10: cmd_ignore is 1 whenever any switch disable, the forced brake or the timer freeze is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ot_raw | input | 1 | Raw over-temperature comparator flag |
| uv_raw | input | 1 | Raw under-voltage comparator flag |
| ov_raw | input | 1 | Raw over-voltage comparator flag |
| trig_in | input | 1 | Shutdown trigger input to be buffered |
| hs_off | output | 2 | High-side disable, bit 0 half A, bit 1 half B |
| ls_off | output | 2 | Low-side disable, bit 0 half A, bit 1 half B |
| ls_force | output | 1 | Force both low sides on (brake) |
| tmr_freeze | output | 1 | Hold the run timer at its present count |
| cmd_ignore | output | 1 | Sequencer must ignore direction, trigger and timer events |
| tmr_rearm | output | 1 | One-cycle request to re-arm the run timer |
| reset_req | output | 1 | One-cycle request to reset the sequencer |
| trig_out | output | 1 | Buffered shutdown trigger |

## Verification
The gating outputs are due SYNC_STAGES+DEB_CYCLES+1 cycles after a raw flag changes. A re-arm cycle follows one cycle after the release of the gating, and trig_out follows trig_in after SYNC_STAGES cycles. Each stimulus task stamps its expected result with the absolute cycle number in which it is due. It usually also stamps the old value one cycle earlier. The scoreboard compares at the falling edge of exactly those cycles, so an early or late change is caught as well as a wrong value. Glitches one cycle shorter than the filter window are checked after the point where an accepted change would have shown up.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

  // flag positions inside the synchronized vector
  localparam int unsigned FLG_OT   = 0;
  localparam int unsigned FLG_UV   = 1;
  localparam int unsigned FLG_OV   = 2;
  localparam int unsigned FLG_TRIG = 3;
  localparam int unsigned NUM_FLT  = 3;
  localparam int unsigned NUM_SYNC = 4;

  typedef struct packed {
    logic [1:0] hs_off;
    logic [1:0] ls_off;
    logic       ls_force;
    logic       tmr_freeze;
    logic       cmd_ignore;
    logic       tmr_rearm;
    logic       reset_req;
  } fsv_gate_t;

  localparam fsv_gate_t GATE_IDLE = '0;

endpackage

// File: rtl/fsv_sync.sv
module fsv_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/fsv_debounce.sv
module fsv_debounce #(
  parameter int unsigned DEB_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_in,
  output logic flag_flt
);

  localparam int unsigned CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          mism;

  assign mism = (flag_in != flt_q);

  // next state: count consecutive disagreeing cycles, flip on the last one
  always_comb begin
    cnt_d = '0;
    flt_d = flt_q;
    if (mism) begin
      if (cnt_q == LIM) begin
        flt_d = flag_in;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign flag_flt = flt_q;

endmodule

// File: rtl/fsv_arbiter.sv
module fsv_arbiter
  import fsv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FLT-1:0] flt,
  output fsv_gate_t          gate
);

  fsv_gate_t gate_q, gate_d;
  logic      rearm_pend_q, rearm_pend_d;
  logic      rst_pend_q, rst_pend_d;
  logic      ot, uv, ov;
  logic      upd_en;

  assign ot = flt[FLG_OT];
  assign uv = flt[FLG_UV];
  assign ov = flt[FLG_OV];

  // register update enable: idle output with nothing pending needs no write
  assign upd_en = (|flt) | rearm_pend_q | (gate_q != GATE_IDLE);

  always_comb begin
    gate_d       = GATE_IDLE;
    rearm_pend_d = rearm_pend_q | ot | uv;
    rst_pend_d   = rst_pend_q | ot;
    if (ot) begin
      gate_d.hs_off     = 2'b11;
      gate_d.ls_off     = 2'b11;
      gate_d.cmd_ignore = 1'b1;
    end else if (uv) begin
      gate_d.hs_off     = 2'b11;
      gate_d.ls_force   = 1'b1;
      gate_d.cmd_ignore = 1'b1;
    end else if (rearm_pend_q) begin
      gate_d.hs_off     = 2'b11;
      gate_d.ls_force   = 1'b1;
      gate_d.cmd_ignore = 1'b1;
      gate_d.tmr_rearm  = 1'b1;
      gate_d.reset_req  = rst_pend_q;
      gate_d.tmr_freeze = ov;
      rearm_pend_d      = 1'b0;
      rst_pend_d        = 1'b0;
    end else if (ov) begin
      gate_d.hs_off     = 2'b11;
      gate_d.tmr_freeze = 1'b1;
      gate_d.cmd_ignore = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q       <= GATE_IDLE;
      rearm_pend_q <= 1'b0;
      rst_pend_q   <= 1'b0;
    end else if (upd_en) begin
      gate_q       <= gate_d;
      rearm_pend_q <= rearm_pend_d;
      rst_pend_q   <= rst_pend_d;
    end
  end

  assign gate = gate_q;

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ot_raw,
  input  logic       uv_raw,
  input  logic       ov_raw,
  input  logic       trig_in,
  output logic [1:0] hs_off,
  output logic [1:0] ls_off,
  output logic       ls_force,
  output logic       tmr_freeze,
  output logic       cmd_ignore,
  output logic       tmr_rearm,
  output logic       reset_req,
  output logic       trig_out
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_SYNC-1:0] raw_vec, syn_vec;
  logic [NUM_FLT-1:0]  flt_q;
  fsv_gate_t           gate;

  // reset: assert at once, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    raw_vec           = '0;
    raw_vec[FLG_OT]   = ot_raw;
    raw_vec[FLG_UV]   = uv_raw;
    raw_vec[FLG_OV]   = ov_raw;
    raw_vec[FLG_TRIG] = trig_in;
  end

  fsv_sync #(
    .WIDTH (NUM_SYNC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_in (raw_vec),
    .d_out(syn_vec)
  );

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    fsv_debounce #(
      .DEB_CYCLES(DEB_CYCLES)
    ) u_deb (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .flag_in (syn_vec[f]),
      .flag_flt(flt_q[f])
    );
  end

  fsv_arbiter u_arb (
    .clk  (clk),
    .rst_n(rst_int_n),
    .flt  (flt_q),
    .gate (gate)
  );

  assign hs_off     = gate.hs_off;
  assign ls_off     = gate.ls_off;
  assign ls_force   = gate.ls_force;
  assign tmr_freeze = gate.tmr_freeze;
  assign cmd_ignore = gate.cmd_ignore;
  assign tmr_rearm  = gate.tmr_rearm;
  assign reset_req  = gate.reset_req;
  assign trig_out   = syn_vec[FLG_TRIG];

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] hs_off,
  input logic [1:0] ls_off,
  input logic       ls_force,
  input logic       tmr_freeze,
  input logic       cmd_ignore,
  input logic       tmr_rearm,
  input logic       reset_req,
  input logic [2:0] flt
);

  p_all_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_off == 2'b11) |-> (hs_off == 2'b11 && !ls_force));

  p_brake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> (ls_off == 2'b00 && hs_off == 2'b11));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hs_off) || (|ls_off) || ls_force || tmr_freeze) |-> cmd_ignore);

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rearm |=> !tmr_rearm);

  p_reset_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (tmr_rearm && cmd_ignore));

  p_filtered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ignore) |-> $past(|flt));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ignore) |-> $past(flt == 3'b000));

endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_off    (hs_off),
  .ls_off    (ls_off),
  .ls_force  (ls_force),
  .tmr_freeze(tmr_freeze),
  .cmd_ignore(cmd_ignore),
  .tmr_rearm (tmr_rearm),
  .reset_req (reset_req),
  .flt       (flt_q)
);

// File: tb/fault_supervisor_tb.sv
`timescale 1ns/1ps
module fault_supervisor_tb;

  localparam int SYNC = 2;
  localparam int DEB  = 16;
  localparam int LAT  = SYNC + DEB + 1;

  // gate pattern {hs_off, ls_off, ls_force, tmr_freeze, cmd_ignore, tmr_rearm, reset_req}
  localparam logic [9:0] G_NONE  = 10'b0_11_11_0_0_0_0_0 & 10'h000;
  localparam logic [9:0] G_OT    = 10'b0_11_11_0_0_1_0_0;
  localparam logic [9:0] G_UV    = 10'b0_11_00_1_0_1_0_0;
  localparam logic [9:0] G_OV    = 10'b0_11_00_0_1_1_0_0;
  localparam logic [9:0] G_RCUV  = 10'b0_11_00_1_0_1_1_0;
  localparam logic [9:0] G_RCOT  = 10'b0_11_00_1_0_1_1_1;
  localparam logic [9:0] G_RCOV  = 10'b0_11_00_1_1_1_1_1;
  localparam logic [9:0] M_GATE  = 10'h1FF;
  localparam logic [9:0] M_TRIG  = 10'h200;

  typedef struct {
    int         cyc;
    logic [9:0] exp;
    logic [9:0] msk;
    string      tag;
  } item_t;

  logic clk, rst_n, ot_raw, uv_raw, ov_raw, trig_in;
  logic [1:0] hs_off, ls_off;
  logic ls_force, tmr_freeze, cmd_ignore, tmr_rearm, reset_req, trig_out;

  int    cyc;
  int    checks;
  int    errors;
  bit    done;
  item_t sb_q[$];

  fault_supervisor #(
    .SYNC_STAGES(SYNC),
    .DEB_CYCLES (DEB)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ot_raw    (ot_raw),
    .uv_raw    (uv_raw),
    .ov_raw    (ov_raw),
    .trig_in   (trig_in),
    .hs_off    (hs_off),
    .ls_off    (ls_off),
    .ls_force  (ls_force),
    .tmr_freeze(tmr_freeze),
    .cmd_ignore(cmd_ignore),
    .tmr_rearm (tmr_rearm),
    .reset_req (reset_req),
    .trig_out  (trig_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int d, input logic [9:0] e, input logic [9:0] m, input string tag);
    item_t it;
    it.cyc = cyc + d;
    it.exp = e;
    it.msk = m;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    logic [9:0] obs;
    obs = {trig_out, hs_off, ls_off, ls_force, tmr_freeze, cmd_ignore, tmr_rearm, reset_req};
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      checks++;
      if (sb_q[0].cyc < cyc) begin
        errors++;
        $display("FAIL %s missed slot cyc %0d actual %b expected %b", sb_q[0].tag,
                 sb_q[0].cyc, obs & sb_q[0].msk, sb_q[0].exp & sb_q[0].msk);
      end else if ((obs & sb_q[0].msk) !== (sb_q[0].exp & sb_q[0].msk)) begin
        errors++;
        $display("FAIL %s cyc %0d actual %b expected %b", sb_q[0].tag, cyc,
                 obs & sb_q[0].msk, sb_q[0].exp & sb_q[0].msk);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; ot_raw = 1'b0; uv_raw = 1'b0; ov_raw = 1'b0; trig_in = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(5);

    // R9: reset state
    expect_at(1, G_NONE, M_GATE, "R9");
    wait_cyc(3);

    // R1: glitch one cycle shorter than the window is ignored
    ot_raw = 1'b1;
    expect_at(LAT, G_NONE, M_GATE, "R1");
    expect_at(LAT + 15, G_NONE, M_GATE, "R1");
    wait_cyc(DEB - 1);
    ot_raw = 1'b0;
    wait_cyc(40);

    // R5 / R1: over-voltage accepted exactly after the window
    ov_raw = 1'b1;
    expect_at(LAT - 1, G_NONE, M_GATE, "R1");
    expect_at(LAT, G_OV, M_GATE, "R5");
    wait_cyc(LAT + 5);
    // R2: short drop of the flag does not release
    ov_raw = 1'b0;
    wait_cyc(DEB - 1);
    ov_raw = 1'b1;
    expect_at(LAT + 2, G_OV, M_GATE, "R2");
    wait_cyc(40);
    ov_raw = 1'b0;
    expect_at(LAT - 1, G_OV, M_GATE, "R2");
    expect_at(LAT, G_NONE, M_GATE, "R5");
    expect_at(LAT + 1, G_NONE, M_GATE, "R5");
    wait_cyc(LAT + 5);

    // R6: under-voltage and its re-arm cycle without reset request
    uv_raw = 1'b1;
    expect_at(LAT, G_UV, M_GATE, "R6");
    wait_cyc(LAT + 5);
    uv_raw = 1'b0;
    expect_at(LAT - 1, G_UV, M_GATE, "R6");
    expect_at(LAT, G_RCUV, M_GATE, "R6");
    expect_at(LAT + 1, G_NONE, M_GATE, "R6");
    wait_cyc(LAT + 5);

    // R3 / R8: over-temperature with the trigger buffer still alive
    ot_raw = 1'b1;
    expect_at(LAT, G_OT, M_GATE, "R3");
    wait_cyc(LAT + 2);
    trig_in = 1'b1;
    expect_at(SYNC - 1, 10'h000, M_TRIG, "R8");
    expect_at(SYNC, 10'h200, M_TRIG, "R8");
    wait_cyc(5);
    trig_in = 1'b0;
    expect_at(SYNC, 10'h000, M_TRIG, "R8");
    wait_cyc(5);
    // R4: recovery from over-temperature
    ot_raw = 1'b0;
    expect_at(LAT - 1, G_OT, M_GATE, "R2");
    expect_at(LAT, G_RCOT, M_GATE, "R4");
    expect_at(LAT + 1, G_NONE, M_GATE, "R4");
    wait_cyc(LAT + 5);

    // R7: overlapping faults and priority
    ov_raw = 1'b1;
    expect_at(LAT, G_OV, M_GATE, "R7");
    wait_cyc(LAT + 2);
    uv_raw = 1'b1;
    expect_at(LAT, G_UV, M_GATE, "R7");
    wait_cyc(LAT + 2);
    ot_raw = 1'b1;
    expect_at(LAT, G_OT, M_GATE, "R7");
    wait_cyc(LAT + 2);
    ot_raw = 1'b0;
    expect_at(LAT, G_UV, M_GATE, "R7");
    expect_at(LAT + 1, G_UV, M_GATE, "R7");
    wait_cyc(LAT + 2);
    uv_raw = 1'b0;
    expect_at(LAT, G_RCOV, M_GATE, "R7");
    expect_at(LAT + 1, G_OV, M_GATE, "R7");
    wait_cyc(LAT + 5);
    // R10 holds in every pattern above; final release
    ov_raw = 1'b0;
    expect_at(LAT, G_NONE, M_GATE, "R10");
    wait_cyc(LAT + 5);

    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule